// File: doc/BRIEF.md
# Sampled Four-Way-Agreement Glitch Filter

This block cleans a single asynchronous input line. The raw line is first brought into the filter clock domain by a flip-flop synchronizer. The synchronized value then feeds a small network of three-input lookup-table cells. Three of these cells are registered and act as a three-deep history of past samples. Three are combinational and detect agreement. The last one is registered and holds the filtered output.

The output moves to a new level only when four values are all equal: the live synchronized sample and the three stored samples. That common level must also differ from the current output. In every other cycle the output keeps its value. A level shorter than four filter-clock samples therefore never appears at the output. Once reset is released and the enable is high, filtering runs on its own, and no control traffic is needed.

The truth table of each cell is a fixed parameter, so the network can be read as a port-level programmable logic fabric frozen into one function. The input and output are plain level pins rather than a data stream. They have no valid/ready handshake, and back-pressure does not apply. A sample is taken on every filter-clock edge.

Top module: `glitch_sieve`

## Requirements
- R1: While `rst_n` is low, `pin_clean`, the synchronizer stages and all history samples are 0.
- R2: With `en` high, a level that `pin_raw` holds steady from a sampling edge onward appears on `pin_clean` on the sixth rising edge, counting that first sampling edge as edge 1. The path is two synchronizer flops, three history stages and the output flop.
- R3: A synchronized pulse of 1, 2 or 3 filter-clock cycles, in either polarity, never changes `pin_clean`.
- R4: A synchronized level held for 4 or more filter-clock cycles with `en` high is copied to `pin_clean`. On each enabled edge the history advances by one sample: newest = synchronized input, then newest to middle, then middle to oldest.
- R5: `pin_clean` changes on an enabled edge only when the synchronized sample and all three history samples are equal and differ from `pin_clean`. It then takes that common value. Otherwise it holds, and an agreed value equal to the present output causes no change.
- R6: While `en` is low, the history and `pin_clean` hold; the synchronizer keeps sampling. After `en` rises with the synchronized input steady at a level opposite to a history of three stale samples, the output changes on the fourth rising edge.
- R7: Each lookup cell outputs bit `{in2,in1,in0}` of its 8-bit truth-table parameter, either directly or through an enable-gated flop. The network uses exactly seven cells: three buffer-history cells, an all-ones detector, an all-zeros detector, an agreement cell and the registered output cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Filter sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Filter enable; history and output freeze while low |
| pin_raw | input | 1 | Unsynchronized raw input line |
| pin_clean | output | 1 | Filtered output level |

## Verification
On every cycle, the assertions check three things: the reset-clear state, the one-step shift of the history on enabled edges and its freeze when disabled, and the rule that `pin_clean` moves only on a four-way agreement that differs from it. The exact six-edge latency, the swallowing of one- to three-cycle pulses of both polarities and the four-edge recovery after re-enabling depend on how the raw line was driven across many cycles. Only the directed scenarios can show these, by timing explicit checks against a cycle model built from the requirements.

// File: rtl/gs_pkg.sv
package gs_pkg;

  // Output style of one lookup cell.
  typedef enum logic {
    LUT_COMB = 1'b0,
    LUT_REG  = 1'b1
  } lut_mode_e;

  // Default synchronizer length.
  localparam int SYNC_STAGES_DEF = 2;

  // History depth the agreement tables are written for.
  localparam int HIST_DEPTH = 3;

  // Truth tables, indexed by {in2,in1,in0}.
  // Pass in0 through.
  localparam logic [7:0] TT_BUF0  = 8'hAA;
  // High when all three inputs are 1.
  localparam logic [7:0] TT_AND3  = 8'h80;
  // High when all three inputs are 0.
  localparam logic [7:0] TT_NOR3  = 8'h01;
  // in0 = all-ones, in1 = all-zeros, in2 = oldest sample:
  // high when the oldest sample matches the group that agreed.
  localparam logic [7:0] TT_AGREE = 8'hAC;
  // in0 = agree, in1 = oldest sample, in2 = present output:
  // next = agree ? oldest : present.
  localparam logic [7:0] TT_NEXT  = 8'hD8;

endpackage

// File: rtl/gs_sync.sv
module gs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/gs_lut3.sv
module gs_lut3
  import gs_pkg::*;
#(
  parameter logic [7:0] TRUTH = 8'h00,
  parameter lut_mode_e  MODE  = LUT_COMB
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [2:0] sel,
  output logic       y
);

  logic look;
  assign look = TRUTH[sel];

  generate
    if (MODE == LUT_REG) begin : g_reg
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= 1'b0;
        else if (en) q <= look;
      end
      assign y = q;
    end else begin : g_comb
      logic unused_ctl;
      assign unused_ctl = ^{clk, rst_n, en};
      assign y = look;
    end
  endgenerate

endmodule

// File: rtl/glitch_sieve.sv
module glitch_sieve
  import gs_pkg::*;
#(
  parameter int SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic pin_raw,
  output logic pin_clean
);

  localparam int NH = HIST_DEPTH;

  logic          sync_q;
  logic [NH-1:0] hist_q;   // [0] newest .. [NH-1] oldest
  logic          all_one;
  logic          all_zero;
  logic          agree;

  gs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_raw),
    .q     (sync_q)
  );

  // History: registered buffer cells.
  generate
    for (genvar i = 0; i < NH; i++) begin : g_hist
      logic feed;
      if (i == 0) begin : g_first
        assign feed = sync_q;
      end else begin : g_next
        assign feed = hist_q[i-1];
      end
      gs_lut3 #(.TRUTH(TT_BUF0), .MODE(LUT_REG)) u_cell (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .sel   ({2'b00, feed}),
        .y     (hist_q[i])
      );
    end
  endgenerate

  gs_lut3 #(.TRUTH(TT_AND3), .MODE(LUT_COMB)) u_all_one (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .sel   ({hist_q[1], hist_q[0], sync_q}),
    .y     (all_one)
  );

  gs_lut3 #(.TRUTH(TT_NOR3), .MODE(LUT_COMB)) u_all_zero (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .sel   ({hist_q[1], hist_q[0], sync_q}),
    .y     (all_zero)
  );

  gs_lut3 #(.TRUTH(TT_AGREE), .MODE(LUT_COMB)) u_agree (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .sel   ({hist_q[NH-1], all_zero, all_one}),
    .y     (agree)
  );

  gs_lut3 #(.TRUTH(TT_NEXT), .MODE(LUT_REG)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .sel   ({pin_clean, hist_q[NH-1], agree}),
    .y     (pin_clean)
  );

endmodule

// File: rtl/gs_sieve_chk.sv
module gs_sieve_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       pin_clean,
  input logic       sync_q,
  input logic [2:0] hist_q
);

  logic same4;
  assign same4 = (sync_q == hist_q[0]) && (sync_q == hist_q[1]) &&
                 (sync_q == hist_q[2]);

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (!pin_clean && hist_q == 3'b000 && !sync_q)
        else $error("R1 state not cleared under reset");
    end
  end

  assert_hist_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (hist_q == {$past(hist_q[1:0]), $past(sync_q)}))
    else $error("R4 history did not advance");

  assert_hold_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(hist_q) && $stable(pin_clean)))
    else $error("R6 state moved while disabled");

  assert_take_agreed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && same4 && (sync_q != pin_clean)) |=> (pin_clean == $past(sync_q)))
    else $error("R5 agreed level not taken");

  assert_hold_otherwise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && same4 && (sync_q != pin_clean)) |=> $stable(pin_clean))
    else $error("R5 output moved without agreement");

endmodule

bind glitch_sieve gs_sieve_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .pin_clean (pin_clean),
  .sync_q    (sync_q),
  .hist_q    (hist_q)
);

// File: tb/glitch_sieve_tb_top.sv
`timescale 1ns/1ps
module glitch_sieve_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic en = 1'b0;
  logic pin_raw = 1'b0;
  logic pin_clean;

  int n_chk = 0;
  int n_bad = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  glitch_sieve dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .pin_raw   (pin_raw),
    .pin_clean (pin_clean)
  );

  // Cycle model written from R2, R4, R5, R6.
  logic [1:0] m_sync;
  logic [2:0] m_hist;
  logic       m_out;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sync <= 2'b00; m_hist <= 3'b000; m_out <= 1'b0;
    end else begin
      m_sync <= {m_sync[0], pin_raw};
      if (en) begin
        m_hist <= {m_hist[1:0], m_sync[1]};
        if (m_sync[1] == m_hist[0] && m_sync[1] == m_hist[1] &&
            m_sync[1] == m_hist[2] && m_sync[1] != m_out)
          m_out <= m_sync[1];
      end
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: pin_clean actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) chk("R5 model", pin_clean, m_out);
  end

  task automatic hold(input logic lvl, input int n);
    pin_raw = lvl;
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    chk("R1 under reset", pin_clean, 1'b0);
    rst_n = 1'b1;
    en = 1'b1;
    @(negedge clk);
    chk("R1 after release", pin_clean, 1'b0);
    cmp_on = 1'b1;
  endtask

  task automatic t_latency;
    hold(1'b0, 8);
    pin_raw = 1'b1;
    repeat (5) @(negedge clk);
    chk("R2 edge 5 still old", pin_clean, 1'b0);
    @(negedge clk);
    chk("R2 edge 6 new", pin_clean, 1'b1);
    hold(1'b1, 4);
    pin_raw = 1'b0;
    repeat (5) @(negedge clk);
    chk("R2 falling edge 5", pin_clean, 1'b1);
    @(negedge clk);
    chk("R2 falling edge 6", pin_clean, 1'b0);
  endtask

  task automatic t_short_glitches;
    hold(1'b0, 10);
    for (int len = 1; len <= 3; len++) begin
      hold(1'b1, len);
      pin_raw = 1'b0;
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        chk("R3 high pulse blocked", pin_clean, 1'b0);
      end
    end
    hold(1'b1, 10);
    for (int len = 1; len <= 3; len++) begin
      hold(1'b0, len);
      pin_raw = 1'b1;
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        chk("R3 low pulse blocked", pin_clean, 1'b1);
      end
    end
  endtask

  task automatic t_long_levels;
    hold(1'b0, 10);
    for (int len = 4; len <= 7; len++) begin
      bit seen = 1'b0;
      hold(1'b1, len);
      pin_raw = 1'b0;
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        if (pin_clean) seen = 1'b1;
      end
      chk("R4 long level passes", seen, 1'b1);
      chk("R4 returns low", pin_clean, 1'b0);
    end
  endtask

  task automatic t_same_level;
    hold(1'b1, 10);
    chk("R5 settled high", pin_clean, 1'b1);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk("R5 agreement equal to output holds", pin_clean, 1'b1);
    end
    hold(1'b0, 10);
  endtask

  task automatic t_enable_hold;
    hold(1'b0, 10);
    en = 1'b0;
    pin_raw = 1'b1;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      chk("R6 disabled holds low", pin_clean, 1'b0);
    end
    en = 1'b1;
    repeat (3) @(negedge clk);
    chk("R6 third enabled edge", pin_clean, 1'b0);
    @(negedge clk);
    chk("R6 fourth enabled edge", pin_clean, 1'b1);
    hold(1'b1, 4);
    en = 1'b0;
    pin_raw = 1'b0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      chk("R6 disabled holds high", pin_clean, 1'b1);
    end
    en = 1'b1;
    hold(1'b0, 10);
  endtask

  task automatic t_mixed;
    logic [15:0] lfsr = 16'hACE1;
    for (int s = 0; s < 80; s++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      en = (lfsr[7:5] != 3'b000);
      hold(lfsr[0], 1 + int'(lfsr[4:2]));
    end
    en = 1'b1;
    hold(1'b0, 10);
    chk("R7 network settles low", pin_clean, 1'b0);
  endtask

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset_state();
    t_latency();
    t_short_glitches();
    t_long_levels();
    t_same_level();
    t_enable_hold();
    t_mixed();
    cmp_on = 1'b0;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule